// File: doc/BRIEF.md
# Scatter-Gather Segment to Region Descriptor Splitter

This block sits in front of a bus-master disk DMA engine. It turns a request, given as a stream of scatter-gather segments (a start address and a byte length, plus a flag on the final segment), into the two-word entries of a physical region descriptor table. Each entry holds a base address word and a count/flags word. The entries leave the block on a valid/ready port, at most one entry per cycle.

Every segment is cut into pieces so that no piece crosses a 64 KB address boundary. In the default encoding a whole 64 KB piece is written as two half-size entries, because some engines read a count of zero as zero bytes rather than 64 KB. The last entry of the table carries an end-of-table bit. An alternate word-count encoding is also offered. It requires 32-bit alignment and carries no end-of-table bit. The block keeps one finished entry back, so the final entry can be marked even when the last segment is empty.

A request ends with a one-cycle completion pulse. The pulse may come with one error flag: the table would exceed its capacity, no entry was produced, or a segment was misaligned. On any of these errors the caller falls back to programmed I/O.

Top module: `sg_prd_splitter`

## Requirements
- R1: No entry spans a 64 KB boundary. Each piece is min(remaining length, 0x10000 minus the low 16 address bits), and pieces follow one another in address order.
- R2: The entry base word is the piece start address. In default encoding (alt_mode 0) the count word holds the byte count in bits 15:0, with bits 30:16 zero.
- R3: In default encoding a 64 KB piece becomes two entries with count 0x8000 each. The first is at the piece address and the second at that address plus 0x8000.
- R4: The final entry of a successful request has ent_last_o high. In default encoding it also has bit 31 of the count word set, and no other entry has bit 31 set. This holds even when the final segment has zero length.
- R5: In alternate encoding (alt_mode 1), bits 31:16 of the count word hold (bytes/4 - 1) and bits 15:0 are zero. There is no end-of-table bit, and a 64 KB piece is not split (count field 0x3FFF).
- R6: A request needing more than CAP entries ends with err_ovf_o, and no more than CAP entries are emitted. A request needing exactly CAP entries succeeds.
- R7: A request that produces no entry, such as a single zero-length segment, ends with err_empty_o.
- R8: A segment whose address or length is odd (default encoding), or not a multiple of 4 (alternate encoding), ends the request with err_align_o. No entry is emitted for it, and the remaining segments of that request are accepted and dropped.
- R9: The encoding is taken from alt_mode_i when the first segment of a request is accepted. Changes to alt_mode_i during a request have no effect on that request.
- R10: While ent_valid_o is high and ent_ready_i is low, the entry outputs hold their values.
- R11: After reset, or on a reset in the middle of a request, seg_ready_o is high and ent_valid_o, done_o and all error flags are low.
- R12: done_o is a one-cycle pulse that ends each request, and at most one error flag is high, only together with done_o. On success, done_o rises in the same cycle that the final entry is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_mode_i | input | 1 | 0: default count encoding, 1: alternate word-count encoding |
| seg_valid_i | input | 1 | Segment valid |
| seg_ready_o | output | 1 | Segment accepted when high with valid |
| seg_addr_i | input | ADDR_W | Segment start address |
| seg_len_i | input | LEN_W | Segment length in bytes |
| seg_last_i | input | 1 | Final segment of the request |
| ent_valid_o | output | 1 | Entry valid |
| ent_ready_i | input | 1 | Entry taken when high with valid |
| ent_base_o | output | ADDR_W | Entry base address word |
| ent_ctrl_o | output | 32 | Entry count/flags word |
| ent_last_o | output | 1 | Final entry of the table |
| done_o | output | 1 | Request finished (one cycle) |
| err_ovf_o | output | 1 | Capacity exceeded |
| err_empty_o | output | 1 | No entry produced |
| err_align_o | output | 1 | Misaligned segment |

## Verification
The bench builds the block with a capacity of 6 entries and 20-bit lengths. With that capacity, one 448 KB segment exceeds the table and one 192 KB segment fills it exactly, so both overflow and the exact-capacity edge are reached within a few dozen cycles. The 20-bit length allows single segments that cross several 64 KB boundaries and mix partial and whole 64 KB pieces. A throttled ready pattern stalls the output often enough to exercise the hold slot under backpressure.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  localparam int CTRL_W = 32;
  localparam int PIECE_W = 17;
  localparam logic [PIECE_W-1:0] FULL_PIECE = 17'h10000;
  localparam logic [PIECE_W-1:0] HALF_PIECE = 17'h08000;

  typedef enum logic [1:0] {
    ST_SEG,
    ST_CUT,
    ST_HALF,
    ST_END
  } sgs_state_e;

  typedef enum logic [1:0] {
    ERR_NONE,
    ERR_OVF,
    ERR_ALIGN
  } sgs_err_e;
endpackage

// File: rtl/sgs_cut.sv
module sgs_cut
  import sgs_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic [15:0]        addr_lo_i,
  input  logic [LEN_W-1:0]   rem_i,
  output logic [PIECE_W-1:0] piece_o,
  output logic               full_o
);
  localparam int W = (LEN_W > PIECE_W) ? LEN_W : PIECE_W;

  logic [PIECE_W-1:0] room;
  logic [W-1:0]       rem_x;
  logic [W-1:0]       room_x;

  always_comb begin
    room    = FULL_PIECE - {1'b0, addr_lo_i};
    rem_x   = W'(rem_i);
    room_x  = W'(room);
    piece_o = (rem_x < room_x) ? rem_x[PIECE_W-1:0] : room;
    full_o  = (piece_o == FULL_PIECE);
  end
endmodule

// File: rtl/sgs_enc.sv
module sgs_enc
  import sgs_pkg::*;
(
  input  logic               alt_i,
  input  logic               last_i,
  input  logic [PIECE_W-1:0] bytes_i,
  output logic [CTRL_W-1:0]  ctrl_o
);
  logic [14:0] words_m1;

  always_comb begin
    words_m1 = bytes_i[16:2] - 15'd1;
    if (alt_i) ctrl_o = {1'b0, words_m1, 16'h0000};
    else       ctrl_o = {last_i, 15'h0000, bytes_i[15:0]};
  end
endmodule

// File: rtl/sgs_out_reg.sv
module sgs_out_reg #(
  parameter int DW = 65
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic          free_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] q_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign q_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= d_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sg_prd_splitter.sv
module sg_prd_splitter
  import sgs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int CAP    = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_mode_i,
  input  logic              seg_valid_i,
  output logic              seg_ready_o,
  input  logic [ADDR_W-1:0] seg_addr_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  input  logic              seg_last_i,
  output logic              ent_valid_o,
  input  logic              ent_ready_i,
  output logic [ADDR_W-1:0] ent_base_o,
  output logic [CTRL_W-1:0] ent_ctrl_o,
  output logic              ent_last_o,
  output logic              done_o,
  output logic              err_ovf_o,
  output logic              err_empty_o,
  output logic              err_align_o
);
  localparam int CNT_W = $clog2(CAP + 1);
  localparam int OUT_W = ADDR_W + CTRL_W + 1;

  sgs_state_e         st_q;
  sgs_err_e           err_q;
  logic               first_q, mode_q, cur_last_q, hold_v_q;
  logic [ADDR_W-1:0]  cur_addr_q, hold_base_q;
  logic [LEN_W-1:0]   rem_q;
  logic [PIECE_W-1:0] hold_bytes_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q, e_ovf_q, e_empty_q, e_align_q;

  logic [PIECE_W-1:0] piece;
  logic               full;
  logic               out_free, ovf, in_step, step_go, push_mid, push_fin, end_go;
  logic               seg_acc, eff_alt, misal, seg_end, split;
  logic [ADDR_W-1:0]  new_base;
  logic [PIECE_W-1:0] new_bytes;
  logic [CTRL_W-1:0]  enc_ctrl;
  logic [OUT_W-1:0]   out_q;
  sgs_state_e         nxt_after;

  sgs_cut #(.LEN_W(LEN_W)) u_cut (
    .addr_lo_i (cur_addr_q[15:0]),
    .rem_i     (rem_q),
    .piece_o   (piece),
    .full_o    (full)
  );

  sgs_enc u_enc (
    .alt_i   (mode_q),
    .last_i  (push_fin),
    .bytes_i (hold_bytes_q),
    .ctrl_o  (enc_ctrl)
  );

  sgs_out_reg #(.DW(OUT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (push_mid || push_fin),
    .d_i     ({hold_base_q, enc_ctrl, push_fin}),
    .free_o  (out_free),
    .valid_o (ent_valid_o),
    .ready_i (ent_ready_i),
    .q_o     (out_q)
  );

  assign ent_base_o  = out_q[OUT_W-1 -: ADDR_W];
  assign ent_ctrl_o  = out_q[CTRL_W:1];
  assign ent_last_o  = out_q[0];
  assign seg_ready_o = (st_q == ST_SEG);
  assign done_o      = done_q;
  assign err_ovf_o   = e_ovf_q;
  assign err_empty_o = e_empty_q;
  assign err_align_o = e_align_q;

  always_comb begin
    ovf       = (cnt_q == CNT_W'(CAP));
    in_step   = (st_q == ST_CUT) || (st_q == ST_HALF);
    // a new entry may enter the hold slot only if the old one can move out
    step_go   = in_step && (ovf || !hold_v_q || out_free);
    push_mid  = step_go && !ovf && hold_v_q;
    push_fin  = (st_q == ST_END) && (err_q == ERR_NONE) && hold_v_q && out_free;
    end_go    = (st_q == ST_END) && ((err_q != ERR_NONE) || !hold_v_q || out_free);
    seg_acc   = seg_valid_i && (st_q == ST_SEG);
    eff_alt   = first_q ? alt_mode_i : mode_q;
    misal     = eff_alt ? (|{seg_addr_i[1:0], seg_len_i[1:0]})
                        : (seg_addr_i[0] | seg_len_i[0]);
    seg_end   = (rem_q == LEN_W'(piece));
    split     = (st_q == ST_CUT) && full && !mode_q;
    new_base  = (st_q == ST_HALF) ? cur_addr_q + ADDR_W'(HALF_PIECE) : cur_addr_q;
    new_bytes = ((st_q == ST_HALF) || split) ? HALF_PIECE : piece;
    nxt_after = cur_last_q ? ST_END : ST_SEG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_SEG;
      err_q        <= ERR_NONE;
      first_q      <= 1'b1;
      mode_q       <= 1'b0;
      cur_last_q   <= 1'b0;
      hold_v_q     <= 1'b0;
      cur_addr_q   <= '0;
      hold_base_q  <= '0;
      rem_q        <= '0;
      hold_bytes_q <= '0;
      cnt_q        <= '0;
      done_q       <= 1'b0;
      e_ovf_q      <= 1'b0;
      e_empty_q    <= 1'b0;
      e_align_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      e_ovf_q   <= 1'b0;
      e_empty_q <= 1'b0;
      e_align_q <= 1'b0;
      unique case (st_q)
        ST_SEG: if (seg_acc) begin
          first_q <= 1'b0;
          if (first_q) mode_q <= alt_mode_i;
          if (err_q == ERR_NONE && misal) begin
            err_q <= ERR_ALIGN;
            st_q  <= seg_last_i ? ST_END : ST_SEG;
          end else if (err_q != ERR_NONE || seg_len_i == '0) begin
            st_q  <= seg_last_i ? ST_END : ST_SEG;
          end else begin
            cur_addr_q <= seg_addr_i;
            rem_q      <= seg_len_i;
            cur_last_q <= seg_last_i;
            st_q       <= ST_CUT;
          end
        end
        ST_CUT, ST_HALF: if (step_go) begin
          if (ovf) begin
            err_q <= ERR_OVF;
            st_q  <= nxt_after;
          end else begin
            hold_v_q     <= 1'b1;
            hold_base_q  <= new_base;
            hold_bytes_q <= new_bytes;
            cnt_q        <= cnt_q + 1'b1;
            if (split) begin
              st_q <= ST_HALF;
            end else begin
              cur_addr_q <= cur_addr_q + ADDR_W'(piece);
              rem_q      <= rem_q - LEN_W'(piece);
              st_q       <= seg_end ? nxt_after : ST_CUT;
            end
          end
        end
        ST_END: if (end_go) begin
          done_q    <= 1'b1;
          e_ovf_q   <= (err_q == ERR_OVF);
          e_align_q <= (err_q == ERR_ALIGN);
          e_empty_q <= (err_q == ERR_NONE) && !hold_v_q;
          err_q     <= ERR_NONE;
          cnt_q     <= '0;
          hold_v_q  <= 1'b0;
          first_q   <= 1'b1;
          st_q      <= ST_SEG;
        end
        default: st_q <= ST_SEG;
      endcase
    end
  end
endmodule

// File: rtl/sg_prd_splitter_chk.sv
module sg_prd_splitter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ent_valid_o,
  input logic        ent_ready_i,
  input logic [15:0] base_lo_i,
  input logic [31:0] ent_ctrl_o,
  input logic        ent_last_o,
  input logic        done_o,
  input logic        err_ovf_o,
  input logic        err_empty_o,
  input logic        err_align_o
);
  logic [18:0] span, end_off;
  logic        any_err;

  always_comb begin
    span    = (ent_ctrl_o[15:0] != 16'h0) ? 19'(ent_ctrl_o[15:0])
                                           : ((19'(ent_ctrl_o[31:16]) + 19'd1) << 2);
    end_off = 19'(base_lo_i) + span;
    any_err = err_ovf_o || err_empty_o || err_align_o;
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && !ent_ready_i |=> ent_valid_o && $stable(base_lo_i)
      && $stable(ent_ctrl_o) && $stable(ent_last_o));

  p_no_cross_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o |-> end_off <= 19'h10000);

  p_one_err_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_ovf_o, err_empty_o, err_align_o}));

  p_err_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err |-> done_o);

  p_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_last_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !any_err |-> ent_valid_o && ent_last_o);

  p_eot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && ent_ctrl_o[31] |-> ent_last_o);
endmodule

bind sg_prd_splitter sg_prd_splitter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ent_valid_o (ent_valid_o),
  .ent_ready_i (ent_ready_i),
  .base_lo_i   (ent_base_o[15:0]),
  .ent_ctrl_o  (ent_ctrl_o),
  .ent_last_o  (ent_last_o),
  .done_o      (done_o),
  .err_ovf_o   (err_ovf_o),
  .err_empty_o (err_empty_o),
  .err_align_o (err_align_o)
);

// File: tb/sg_prd_splitter_bench.sv
module sg_prd_splitter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 20;
  localparam int CAP    = 6;
  localparam int NV     = 17;

  // row: {last, alt, addr[31:0], len[19:0]}
  localparam logic [53:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'h0000_1000, 20'h00200},
    {1'b1, 1'b0, 32'h0000_FF00, 20'h00300},
    {1'b1, 1'b0, 32'h0002_0000, 20'h10000},
    {1'b0, 1'b0, 32'h0003_0000, 20'h00100},
    {1'b1, 1'b1, 32'h0005_FFF0, 20'h00020},
    {1'b1, 1'b1, 32'h0007_0000, 20'h10000},
    {1'b1, 1'b1, 32'h0008_FFFC, 20'h00008},
    {1'b0, 1'b0, 32'h000A_0000, 20'h00040},
    {1'b1, 1'b0, 32'h000B_0000, 20'h00000},
    {1'b1, 1'b0, 32'h000C_0000, 20'h00000},
    {1'b1, 1'b0, 32'h0010_0000, 20'h70000},
    {1'b1, 1'b0, 32'h0000_1001, 20'h00002},
    {1'b1, 1'b1, 32'h0000_2002, 20'h00004},
    {1'b0, 1'b0, 32'h0000_3003, 20'h00010},
    {1'b1, 1'b0, 32'h0004_0000, 20'h00020},
    {1'b1, 1'b0, 32'h0020_0000, 20'h30000},
    {1'b1, 1'b0, 32'h0030_8000, 20'h18000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alt_mode = 1'b0;
  logic              seg_valid = 1'b0;
  logic              seg_ready;
  logic [ADDR_W-1:0] seg_addr = '0;
  logic [LEN_W-1:0]  seg_len = '0;
  logic              seg_last = 1'b0;
  logic              ent_valid;
  logic              ent_ready = 1'b0;
  logic [ADDR_W-1:0] ent_base;
  logic [31:0]       ent_ctrl;
  logic              ent_last;
  logic              done, e_ovf, e_empty, e_align;

  sg_prd_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP(CAP)) u_sg_prd_splitter (
    .clk_i(clk), .rst_ni(rst_n), .alt_mode_i(alt_mode),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready), .seg_addr_i(seg_addr),
    .seg_len_i(seg_len), .seg_last_i(seg_last),
    .ent_valid_o(ent_valid), .ent_ready_i(ent_ready), .ent_base_o(ent_base),
    .ent_ctrl_o(ent_ctrl), .ent_last_o(ent_last), .done_o(done),
    .err_ovf_o(e_ovf), .err_empty_o(e_empty), .err_align_o(e_align)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // received entries
  logic [31:0] rx_base [64];
  logic [31:0] rx_ctrl [64];
  logic        rx_last [64];
  int          rx_n = 0;
  int          rdy_ctr = 0;
  logic        stall_prev = 1'b0;
  logic [64:0] stall_data = '0;

  always @(negedge clk) begin
    rdy_ctr++;
    ent_ready = ((rdy_ctr % 5) != 2);
    if (rst_n) begin
      if (stall_prev)
        chk(ent_valid && {ent_base, ent_ctrl, ent_last} == stall_data, "R10 stall hold",
            64'({ent_base, ent_ctrl}), 64'(stall_data[64:1]));
      stall_prev = ent_valid && !ent_ready;
      stall_data = {ent_base, ent_ctrl, ent_last};
      if (ent_valid && ent_ready && rx_n < 64) begin
        rx_base[rx_n] = ent_base;
        rx_ctrl[rx_n] = ent_ctrl;
        rx_last[rx_n] = ent_last;
        rx_n++;
      end
    end else begin
      stall_prev = 1'b0;
    end
  end

  // reference model of one request
  logic [31:0] exp_base  [64];
  logic [16:0] exp_bytes [64];
  logic        exp_split [64];
  int          exp_n;
  int          req_err;   // 0 none, 1 overflow, 2 empty, 3 align
  logic        req_alt;
  logic        req_mix;

  task automatic push(input logic [31:0] b, input logic [16:0] n, input logic s);
    if (exp_n == CAP) req_err = 1;
    else begin
      exp_base[exp_n] = b; exp_bytes[exp_n] = n; exp_split[exp_n] = s; exp_n++;
    end
  endtask

  task automatic model_seg(input logic [31:0] a0, input logic [19:0] l0);
    logic [31:0] a, r, room, p;
    if (req_err != 0) return;
    if (req_alt ? (a0[1:0] != 0 || l0[1:0] != 0) : (a0[0] || l0[0])) begin
      req_err = 3;
      return;
    end
    a = a0; r = 32'(l0);
    while (r != 0) begin
      room = 32'h10000 - 32'(a[15:0]);
      p = (r < room) ? r : room;
      if (!req_alt && p == 32'h10000) begin
        push(a, 17'h08000, 1'b1);
        if (req_err == 0) push(a + 32'h8000, 17'h08000, 1'b1);
      end else push(a, p[16:0], 1'b0);
      if (req_err != 0) return;
      a = a + p; r = r - p;
    end
  endtask

  task automatic drive_seg(input logic alt, input logic [31:0] a, input logic [19:0] l, input logic last);
    @(negedge clk);
    alt_mode = alt; seg_addr = a; seg_len = l; seg_last = last; seg_valid = 1'b1;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic finish_req();
    int got;
    logic [31:0] ec;
    string tag;
    while (!done) @(negedge clk);
    got = e_ovf ? 1 : e_empty ? 2 : e_align ? 3 : 0;
    tag = (req_err == 1) ? "R6 overflow flag" : (req_err == 2) ? "R7 empty flag" :
          (req_err == 3) ? "R8 align flag" : "R12 no error";
    chk(got == req_err, tag, 64'(got), 64'(req_err));
    chk(32'(e_ovf) + 32'(e_empty) + 32'(e_align) <= 1, "R12 single flag",
        64'({e_ovf, e_empty, e_align}), 64'h1);
    if (req_err == 0)
      chk(ent_valid && ent_last, "R12 final entry with done", 64'({ent_valid, ent_last}), 64'h3);
    @(negedge clk);
    chk(!done, "R12 one-cycle pulse", 64'(done), 64'h0);
    while (ent_valid) @(negedge clk);
    if (req_err == 0) begin
      chk(rx_n == exp_n, "R2 entry count", 64'(rx_n), 64'(exp_n));
      for (int i = 0; i < exp_n && i < rx_n; i++) begin
        if (req_alt) ec = {1'b0, exp_bytes[i][16:2] - 15'd1, 16'h0000};
        else         ec = {(i == exp_n - 1), 15'h0000, exp_bytes[i][15:0]};
        tag = req_alt ? "R5 alt count" : exp_split[i] ? "R3 half split" :
              (i == exp_n - 1) ? "R4 end of table" : "R2 count word";
        chk(rx_base[i] == exp_base[i], "R2 base word", 64'(rx_base[i]), 64'(exp_base[i]));
        chk(rx_ctrl[i] == ec, tag, 64'(rx_ctrl[i]), 64'(ec));
        chk(rx_last[i] == (i == exp_n - 1), "R4 last flag", 64'(rx_last[i]), 64'(i == exp_n - 1));
        chk(32'(rx_base[i][15:0]) + 32'(exp_bytes[i]) <= 32'h10000, "R1 boundary",
            64'(rx_base[i][15:0]) + 64'(exp_bytes[i]), 64'h10000);
      end
      if (req_mix)
        for (int i = 0; i < rx_n; i++)
          chk(rx_ctrl[i][15:0] != 16'h0, "R9 mode latched", 64'(rx_ctrl[i]), 64'h1);
    end
    if (req_err == 3) chk(rx_n == 0, "R8 nothing emitted", 64'(rx_n), 64'h0);
    if (req_err == 1) chk(rx_n <= CAP, "R6 bounded output", 64'(rx_n), 64'(CAP));
  endtask

  task automatic start_req(input logic alt);
    req_err = 0; exp_n = 0; rx_n = 0; req_alt = alt; req_mix = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic newreq;
    logic [53:0] row;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_ready && !ent_valid && !done && !e_ovf && !e_empty && !e_align, "R11 reset state",
        64'({seg_ready, ent_valid, done, e_ovf, e_empty, e_align}), 64'h20);

    newreq = 1'b1;
    for (int i = 0; i < NV; i++) begin
      row = VEC[i];
      if (newreq) begin start_req(row[52]); newreq = 1'b0; end
      if (row[52] != req_alt) req_mix = 1'b1;
      model_seg(row[51:20], row[19:0]);
      drive_seg(row[52], row[51:20], row[19:0], row[53]);
      if (row[53]) begin
        if (req_err == 0 && exp_n == 0) req_err = 2;
        finish_req();
        newreq = 1'b1;
      end
    end

    // reset in the middle of a long request
    drive_seg(1'b0, 32'h0040_0000, 20'h40000, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(seg_ready && !ent_valid && !done && !e_ovf && !e_empty && !e_align, "R11 mid-request reset",
        64'({seg_ready, ent_valid, done, e_ovf, e_empty, e_align}), 64'h20);
    rst_n = 1'b1;
    start_req(1'b0);
    model_seg(32'h0000_4000, 20'h00080);
    drive_seg(1'b0, 32'h0000_4000, 20'h00080, 1'b1);
    finish_req();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule